// File: doc/BRIEF.md
# Oscillator Frequency Measurement Counter

This block estimates the frequency of a fast oscillator. It opens a gate for a programmable number of reference-clock cycles and counts the oscillator's rising edges while the gate is open. The gate length is a power of two: an encoded window code N gives 2^(N+1) reference cycles. After the gate closes, the edge total is captured in the reference domain and reported, together with a busy indication, a one-cycle completion pulse and a sticky completion flag that can raise an interrupt.

Software drives the block through level configuration inputs and single-cycle command strobes, all in the reference domain. A manual override mode replaces the clear and run strobes with level bits, whose rising edges act as commands. In this mode, a falling edge of the manual run bit closes a window early. The gate opening and closing reach the oscillator domain through synchronizers, and so does the clear request, which is carried as a toggle. The gate state seen in the oscillator domain is synchronized back, so the count is read only after the oscillator side has stopped counting. The oscillator must run faster than the reference clock.

Successive windows add to the count until a clear is issued. The count saturates at its maximum value and does not wrap.

Top module: `osc_freq_meter`

## Requirements
- R1: After reset, `count_out`, `busy`, `done_pulse`, `done_flag` and `irq` are all 0.
- R2: A run opens the gate for exactly 2^(N+1) reference cycles, where N is `cfg_window` and ranges over 0..12. The count grows by the number of oscillator edges in that time: 80 × 2^(N+1) when the oscillator runs 80 times faster than the reference.
- R3: Window codes 13, 14 and 15 behave as code 12 (8192 cycles).
- R4: Runs that follow one another without a clear add to the count. An accepted clear sets the reported count to 0 and zeroes the oscillator-side counter.
- R5: The 19-bit count saturates at 524287 and never wraps.
- R6: `count_out` is registered. It shows 0 one cycle after `cfg_read_en` is 0, and it shows the latest captured count one cycle after `cfg_read_en` is 1.
- R7: `busy` goes high on the cycle after a run is accepted and stays high until the count is captured. It falls together with a single-cycle `done_pulse`. Run and clear requests that arrive while `busy` is high are ignored.
- R8: When `cfg_ovr_en` is 1, `cmd_run` and `cmd_clear` are ignored. A rising edge of `cfg_man_run` starts a window, and a rising edge of `cfg_man_clear` clears the count.
- R9: When `cfg_ovr_en` is 1, a falling edge of `cfg_man_run` during an open window closes the gate on that edge. The count then covers only the cycles the gate was open.
- R10: When `cfg_enable` is 0, run and clear requests from either path are ignored: no window starts and the count is kept. A window already under way runs to completion.
- R11: `done_flag` is set by `done_pulse` and stays set until `flag_clr` is pulsed. If both happen in the same cycle, the set wins. `irq` is a register that follows `done_flag & irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset (reference domain) |
| osc_clk | input | 1 | Oscillator being measured |
| cfg_enable | input | 1 | Global enable for starting and clearing |
| cfg_read_en | input | 1 | 1 shows the count, 0 forces the output to zero |
| cfg_window | input | 4 | Window code N; the gate lasts 2^(N+1) reference cycles |
| cfg_ovr_en | input | 1 | Selects the manual clear/run bits in place of the strobes |
| cfg_man_clear | input | 1 | Manual clear level; its rising edge clears |
| cfg_man_run | input | 1 | Manual run level; its rising edge starts, its falling edge stops |
| cmd_clear | input | 1 | Single-cycle clear strobe |
| cmd_run | input | 1 | Single-cycle run strobe |
| irq_en | input | 1 | Interrupt enable for the completion flag |
| flag_clr | input | 1 | Single-cycle clear for the completion flag |
| count_out | output | 19 | Gated, captured edge count |
| busy | output | 1 | High while a measurement is in progress |
| done_pulse | output | 1 | One-cycle pulse when a measurement completes |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest state to reach is saturation. The counter must pass 524287 edges, which is not possible at ordinary frequency ratios or with short windows. The stimulus uses an 80:1 oscillator-to-reference ratio and the longest window, so about 655 thousand edges arrive and the counter sits at its ceiling for more than a thousand reference cycles. An early stop is also hard to produce: the manual run level has to fall while the gate is open, in override mode only. The stimulus lowers it ten cycles after raising it, during an 8192-cycle window, and expects exactly ten cycles' worth of edges.

// File: rtl/ofm_pkg.sv
package ofm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_OPEN      = 2'd1,
    ST_SETTLE_HI = 2'd2,
    ST_SETTLE_LO = 2'd3
  } win_state_t;
endpackage

// File: rtl/ofm_sync.sv
module ofm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ofm_req_mux.sv
module ofm_req_mux (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic ovr_en,
  input  logic man_clear,
  input  logic man_run,
  input  logic cmd_clear,
  input  logic cmd_run,
  output logic start_req,
  output logic stop_req,
  output logic clear_req
);
  logic man_run_q;
  logic man_clr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      man_run_q <= 1'b0;
      man_clr_q <= 1'b0;
    end else begin
      man_run_q <= man_run;
      man_clr_q <= man_clear;
    end
  end

  logic run_rise, run_fall, clr_rise;
  assign run_rise = man_run & ~man_run_q;
  assign run_fall = ~man_run & man_run_q;
  assign clr_rise = man_clear & ~man_clr_q;

  always_comb begin
    start_req = enable & (ovr_en ? run_rise : cmd_run);
    clear_req = enable & (ovr_en ? clr_rise : cmd_clear);
    stop_req  = ovr_en & run_fall;
  end
endmodule

// File: rtl/ofm_win_ctrl.sv
module ofm_win_ctrl
  import ofm_pkg::*;
#(
  parameter int CNT_W   = 19,
  parameter int SEL_W   = 4,
  parameter int SEL_MAX = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             clear_req,
  input  logic [SEL_W-1:0] sel,
  input  logic             ack,
  input  logic [CNT_W-1:0] osc_count,
  output logic             gate,
  output logic             clr_tgl,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] count
);
  localparam int TMR_W = SEL_MAX + 1;
  localparam logic [SEL_W-1:0] SEL_CAP = SEL_W'(SEL_MAX);

  win_state_t       state_q;
  logic [TMR_W-1:0] timer_q;
  logic [SEL_W-1:0] sel_eff;
  logic [TMR_W-1:0] win_m1;

  always_comb begin
    sel_eff = (sel > SEL_CAP) ? SEL_CAP : sel;
    win_m1  = {TMR_W{1'b1}} >> (SEL_CAP - sel_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      timer_q <= '0;
      gate    <= 1'b0;
      clr_tgl <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      count   <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_req) begin
            state_q <= ST_OPEN;
            gate    <= 1'b1;
            busy    <= 1'b1;
            timer_q <= win_m1;
          end else if (clear_req) begin
            clr_tgl <= ~clr_tgl;
            count   <= '0;
          end
        end
        ST_OPEN: begin
          if (stop_req || timer_q == '0) begin
            gate    <= 1'b0;
            state_q <= ST_SETTLE_HI;
          end else begin
            timer_q <= timer_q - 1'b1;
          end
        end
        ST_SETTLE_HI: begin
          if (ack) state_q <= ST_SETTLE_LO;
        end
        default: begin
          if (!ack) begin
            count   <= osc_count;
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R7
  AST_GATE_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> ($past(state_q) == ST_IDLE)); // R7
  AST_CLEAR_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$stable(clr_tgl) |-> ($past(state_q) == ST_IDLE)); // R7
endmodule

// File: rtl/ofm_edge_cnt.sv
module ofm_edge_cnt #(
  parameter int CNT_W       = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic             osc_clk,
  input  logic             rst_ref,
  input  logic             gate_ref,
  input  logic             clr_tgl_ref,
  output logic             gate_osc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic osc_rst;
  logic gate_s;
  logic clr_s;
  logic clr_prev;
  logic clr_hit;

  ofm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(osc_clk), .rst(1'b0), .d(rst_ref), .q(osc_rst));

  ofm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(osc_clk), .rst(osc_rst), .d(gate_ref), .q(gate_s));

  ofm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(osc_clk), .rst(osc_rst), .d(clr_tgl_ref), .q(clr_s));

  assign clr_hit = clr_s ^ clr_prev;

  always_ff @(posedge osc_clk) begin
    if (osc_rst) begin
      clr_prev <= 1'b0;
      gate_osc <= 1'b0;
      count    <= '0;
    end else begin
      clr_prev <= clr_s;
      gate_osc <= gate_s;
      if (clr_hit)
        count <= '0;
      else if (gate_osc && count != CNT_MAX)
        count <= count + 1'b1;
    end
  end

  AST_NO_WRAP: assert property (@(posedge osc_clk) disable iff (osc_rst)
    ($past(count) == CNT_MAX && !$past(clr_hit)) |-> (count == CNT_MAX)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge osc_clk) disable iff (osc_rst)
    (!$past(gate_osc) && !$past(clr_hit)) |-> $stable(count)); // R2
endmodule

// File: rtl/ofm_irq.sv
module ofm_irq (
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic flag_clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_next;
  assign flag_next = done | (flag & ~flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_next;
      irq  <= flag_next & irq_en;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag); // R11
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en)); // R11
endmodule

// File: rtl/osc_freq_meter.sv
module osc_freq_meter #(
  parameter int CNT_W       = 19,
  parameter int SEL_W       = 4,
  parameter int SEL_MAX     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_clk,
  input  logic             cfg_enable,
  input  logic             cfg_read_en,
  input  logic [SEL_W-1:0] cfg_window,
  input  logic             cfg_ovr_en,
  input  logic             cfg_man_clear,
  input  logic             cfg_man_run,
  input  logic             cmd_clear,
  input  logic             cmd_run,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_out,
  output logic             busy,
  output logic             done_pulse,
  output logic             done_flag,
  output logic             irq
);
  logic             start_req, stop_req, clear_req;
  logic             gate_ref, clr_tgl;
  logic             gate_osc, ack;
  logic [CNT_W-1:0] osc_count;
  logic [CNT_W-1:0] cap_count;

  ofm_req_mux u_req (
    .clk(clk), .rst(rst), .enable(cfg_enable), .ovr_en(cfg_ovr_en),
    .man_clear(cfg_man_clear), .man_run(cfg_man_run),
    .cmd_clear(cmd_clear), .cmd_run(cmd_run),
    .start_req(start_req), .stop_req(stop_req), .clear_req(clear_req));

  ofm_win_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W), .SEL_MAX(SEL_MAX)) u_win (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .clear_req(clear_req), .sel(cfg_window), .ack(ack), .osc_count(osc_count),
    .gate(gate_ref), .clr_tgl(clr_tgl), .busy(busy), .done(done_pulse),
    .count(cap_count));

  ofm_edge_cnt #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
    .osc_clk(osc_clk), .rst_ref(rst), .gate_ref(gate_ref),
    .clr_tgl_ref(clr_tgl), .gate_osc(gate_osc), .count(osc_count));

  ofm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d(gate_osc), .q(ack));

  ofm_irq u_irq (
    .clk(clk), .rst(rst), .done(done_pulse), .flag_clr(flag_clr),
    .irq_en(irq_en), .flag(done_flag), .irq(irq));

  always_ff @(posedge clk) begin
    if (rst) count_out <= '0;
    else     count_out <= cfg_read_en ? cap_count : '0;
  end

  AST_READ_GATE: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_read_en) |-> (count_out == '0)); // R6
  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!cfg_enable && !busy) |=> !busy); // R10
endmodule

// File: tb/osc_freq_meter_bench.sv
`timescale 1ns/1ps
module osc_freq_meter_bench;
  localparam int RATIO = 80;
  localparam int CMAX  = 524287;

  logic        clk = 1'b0;
  logic        osc_clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b1, cfg_read_en = 1'b1, cfg_ovr_en = 1'b0;
  logic        cfg_man_clear = 1'b0, cfg_man_run = 1'b0;
  logic [3:0]  cfg_window = 4'd0;
  logic        cmd_clear = 1'b0, cmd_run = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic [18:0] count_out;
  logic        busy, done_pulse, done_flag, irq;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;
  initial begin
    #0.05;
    forever #0.125 osc_clk = ~osc_clk;
  end

  osc_freq_meter u_osc_freq_meter (
    .clk(clk), .rst(rst), .osc_clk(osc_clk),
    .cfg_enable(cfg_enable), .cfg_read_en(cfg_read_en), .cfg_window(cfg_window),
    .cfg_ovr_en(cfg_ovr_en), .cfg_man_clear(cfg_man_clear), .cfg_man_run(cfg_man_run),
    .cmd_clear(cmd_clear), .cmd_run(cmd_run), .irq_en(irq_en), .flag_clr(flag_clr),
    .count_out(count_out), .busy(busy), .done_pulse(done_pulse),
    .done_flag(done_flag), .irq(irq));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input longint act, input longint exp, input int tol);
    vectors++;
    if (act < exp - tol || act > exp + tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_clear();
    cmd_clear = 1'b1; tick(1); cmd_clear = 1'b0; tick(6);
  endtask

  task automatic wait_idle(output int len, output int dones);
    len = 0; dones = 0;
    while (busy && len < 20000) begin
      if (done_pulse) dones++;
      len++;
      tick(1);
    end
    if (done_pulse) dones++;
    tick(2);
  endtask

  task automatic run_win(input logic [3:0] sel, output int len, output int dones);
    cfg_window = sel;
    cmd_run = 1'b1; tick(1); cmd_run = 1'b0;
    wait_idle(len, dones);
  endtask

  task automatic t_reset();
    check("R1 count", count_out, 0, 0);
    check("R1 busy", busy, 0, 0);
    check("R1 done", done_pulse, 0, 0);
    check("R1 flag", done_flag, 0, 0);
    check("R1 irq", irq, 0, 0);
  endtask

  task automatic t_window();
    int len, dn;
    pulse_clear();
    run_win(4'd0, len, dn);
    check("R2 code0 count", count_out, 2 * RATIO, 2);
    check("R7 busy covers window", (len >= 2) ? 1 : 0, 1, 0);
    check("R7 one done pulse", dn, 1, 0);
    pulse_clear();
    run_win(4'd4, len, dn);
    check("R2 code4 count", count_out, 32 * RATIO, 2);
    check("R7 busy length code4", (len >= 32 && len < 40) ? 1 : 0, 1, 0);
  endtask

  task automatic t_accum();
    int len, dn;
    pulse_clear();
    run_win(4'd1, len, dn);
    check("R4 first run", count_out, 4 * RATIO, 2);
    run_win(4'd1, len, dn);
    check("R4 accumulated", count_out, 8 * RATIO, 3);
    pulse_clear();
    tick(1);
    check("R4 clear zeroes", count_out, 0, 0);
  endtask

  task automatic t_busy_ignore();
    int len, dn;
    pulse_clear();
    run_win(4'd2, len, dn);
    cfg_window = 4'd3;
    cmd_run = 1'b1; tick(1); cmd_run = 1'b0;
    tick(3);
    cmd_run = 1'b1; cmd_clear = 1'b1; tick(1); cmd_run = 1'b0; cmd_clear = 1'b0;
    wait_idle(len, dn);
    check("R7 run/clear while busy ignored", count_out, 24 * RATIO, 3);
    check("R7 single done", dn, 1, 0);
  endtask

  task automatic t_read_gate();
    cfg_read_en = 1'b0; tick(1);
    check("R6 gated to zero", count_out, 0, 0);
    cfg_read_en = 1'b1; tick(1);
    check("R6 shows count", count_out, 24 * RATIO, 3);
  endtask

  task automatic t_sat_and_clamp();
    int len12, len15, dn;
    pulse_clear();
    run_win(4'd12, len12, dn);
    check("R5 saturates", count_out, CMAX, 0);
    pulse_clear();
    run_win(4'd15, len15, dn);
    check("R3 code15 saturates", count_out, CMAX, 0);
    check("R3 code15 busy same as code12", len15, len12, 1);
    check("R3 code12 length", (len12 >= 8192 && len12 < 8200) ? 1 : 0, 1, 0);
  endtask

  task automatic t_enable();
    cfg_enable = 1'b0;
    cfg_window = 4'd0;
    cmd_run = 1'b1; tick(1); cmd_run = 1'b0; tick(3);
    check("R10 no start when disabled", busy, 0, 0);
    pulse_clear(); tick(1);
    check("R10 no clear when disabled", count_out, CMAX, 0);
    cfg_enable = 1'b1;
  endtask

  task automatic t_override();
    int len, dn;
    cfg_ovr_en = 1'b1;
    pulse_clear(); tick(1);
    check("R8 strobe clear ignored", count_out, CMAX, 0);
    cfg_man_clear = 1'b1; tick(6); cfg_man_clear = 1'b0; tick(1);
    check("R8 manual clear", count_out, 0, 0);
    cfg_window = 4'd0;
    cmd_run = 1'b1; tick(1); cmd_run = 1'b0; tick(2);
    check("R8 strobe run ignored", busy, 0, 0);
    cfg_man_run = 1'b1; tick(1);
    wait_idle(len, dn);
    check("R8 manual run count", count_out, 2 * RATIO, 2);
    cfg_man_run = 1'b0; tick(2);
    cfg_man_clear = 1'b1; tick(6); cfg_man_clear = 1'b0; tick(1);
    cfg_window = 4'd12;
    cfg_man_run = 1'b1; tick(10); cfg_man_run = 1'b0;
    wait_idle(len, dn);
    check("R9 early stop count", count_out, 10 * RATIO, 2);
    check("R9 early stop busy short", (len < 30) ? 1 : 0, 1, 0);
    cfg_ovr_en = 1'b0;
  endtask

  task automatic t_irq();
    int len, dn;
    irq_en = 1'b0; tick(1);
    check("R11 flag sticky", done_flag, 1, 0);
    check("R11 irq masked", irq, 0, 0);
    irq_en = 1'b1; tick(1);
    check("R11 irq follows flag", irq, 1, 0);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    check("R11 flag cleared", done_flag, 0, 0);
    check("R11 irq drops", irq, 0, 0);
    run_win(4'd0, len, dn);
    check("R11 flag set on done", done_flag, 1, 0);
    check("R11 irq on done", irq, 1, 0);
  endtask

  initial begin
    tick(10);
    rst = 1'b0;
    tick(4);
    t_reset();
    t_window();
    t_accum();
    t_busy_ignore();
    t_read_gate();
    t_sat_and_clamp();
    t_enable();
    t_override();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule